// File: doc/BRIEF.md
# Serial Control-DAC Word Loader

This block takes command words from a three-wire serial port and keeps one 8-bit code for each of two control-DAC channels. The port has a serial clock, a data line and an enable line that is active low. All three pins are brought into the system clock domain through synchronizer chains, and the block detects their edges in that domain. The serial clock must therefore toggle well below the system clock rate.

A load cycle starts when the enable line goes low. While enable stays low, the block takes one data bit on each rising serial-clock edge, most significant bit first. A word is twelve bits long. The earliest bit picks the channel. The three bits after it are padding and carry no meaning. The last eight bits are the code. The chosen channel's register takes the new code only when enable returns high, and only if exactly twelve bits arrived. The DAC-enable flag reports the converters as disabled whenever the enable line is high.

Top module: `ctl_dac_loader`

## Requirements
- R1: After reset, `code_ch0` and `code_ch1` are 0 and `dac_on` is 0.
- R2: `dac_on` is 1 while `ser_en_n` is low and 0 while it is high. It follows the pin after a latency of SYNC_STAGES system clocks.
- R3: Bits are captured on rising `ser_clk` edges while `ser_en_n` is low, most significant bit first. The first bit received ends up in word bit 11.
- R4: The first bit of a word selects the channel. A value of 0 writes `code_ch0` and a value of 1 writes `code_ch1`.
- R5: Bits 2 to 4 of a word (word bits 10..8) have no effect on either output.
- R6: The last eight bits received (word bits 7..0) become the code of the selected channel. Bit 7 is the most significant bit of the code.
- R7: The output registers never change during shifting. They change only in the system clock cycle that follows detection of the rising edge of `ser_en_n`.
- R8: A word that ends with a count of bits other than exactly 12, whether shorter or longer, leaves both outputs unchanged.
- R9: A committed word leaves the channel it did not select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_en_n | input | 1 | Serial enable, active low; a low level frames a word |
| code_ch0 | output | 8 | Code register of channel 0 |
| code_ch1 | output | 8 | Code register of channel 1 |
| dac_on | output | 1 | 1 while the converters are enabled |

## Verification
On every cycle, the assertions check four things. The output codes change only one cycle after an enable rising edge. They change only when the bit count stood at exactly twelve. At most one channel moves at a time. The bit counter never runs past its saturation value. Other behaviour can be shown only by the bench's scenarios: bit ordering, the placement of the select, padding and code fields, and the rejection of short and long words. The bench drives chosen frames and compares every cycle against a behavioural model that works at the pins.

// File: rtl/dl_pkg.sv
package dl_pkg;
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_START = 2'd1,
      EV_BIT   = 2'd2,
      EV_END   = 2'd3
   } dl_ev_e;
endpackage

// File: rtl/dl_sync.sv
module dl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dl_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dl_shift.sv
module dl_shift #(
   parameter int WORD_W = 12,
   parameter int CODE_W = 8,
   parameter int SEL_W  = 1,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              din,
   output logic [SEL_W-1:0]  sel_o,
   output logic [CODE_W-1:0] code_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (clr) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (shift) begin
         sreg <= {sreg[WORD_W-2:0], din};
         if (cnt < CNT_SAT) cnt <= cnt + 1'b1;
      end
   end

   assign sel_o  = sreg[WORD_W-1 -: SEL_W];
   assign code_o = sreg[CODE_W-1:0];
   assign cnt_o  = cnt;
endmodule

// File: rtl/dl_bank.sv
module dl_bank #(
   parameter int CODE_W = 8,
   parameter int SEL_W  = 1,
   parameter int NUM_CH = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [SEL_W-1:0]         sel,
   input  logic [CODE_W-1:0]        code,
   output logic [NUM_CH*CODE_W-1:0] codes
);
   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic [CODE_W-1:0] reg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             reg_q <= '0;
            else if (load && (sel == SEL_W'(g)))   reg_q <= code;
         end
         assign codes[g*CODE_W +: CODE_W] = reg_q;
      end
   endgenerate
endmodule

// File: rtl/ctl_dac_loader.sv
module ctl_dac_loader #(
   parameter int WORD_W      = 12,
   parameter int CODE_W      = 8,
   parameter int PAD_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_en_n,
   output logic [CODE_W-1:0] code_ch0,
   output logic [CODE_W-1:0] code_ch1,
   output logic              dac_on
);
   import dl_pkg::*;

   localparam int SEL_W  = WORD_W - PAD_W - CODE_W;
   localparam int NUM_CH = 1 << SEL_W;
   localparam int CNT_W  = $clog2(WORD_W + 2);

   generate
      if (SEL_W != 1) begin : g_bad_frame
         $error("ctl_dac_loader: frame must leave exactly one select bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctl_dac_loader: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic clk_s, dat_s, en_s;
   logic clk_p, en_p;
   dl_ev_e ev;
   logic [SEL_W-1:0]  sel_w;
   logic [CODE_W-1:0] code_w;
   logic [CNT_W-1:0]  bit_cnt;
   logic              load;
   logic [NUM_CH*CODE_W-1:0] codes;

   dl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(clk_s));
   dl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_dat), .q(dat_s));
   dl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(ser_en_n), .q(en_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_p <= 1'b0;
         en_p  <= 1'b1;
      end else begin
         clk_p <= clk_s;
         en_p  <= en_s;
      end
   end

   always_comb begin
      if (en_s && !en_p)                     ev = EV_END;
      else if (!en_s && en_p)                ev = EV_START;
      else if (!en_s && clk_s && !clk_p)     ev = EV_BIT;
      else                                   ev = EV_NONE;
   end

   dl_shift #(.WORD_W(WORD_W), .CODE_W(CODE_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clr(ev == EV_START), .shift(ev == EV_BIT), .din(dat_s),
      .sel_o(sel_w), .code_o(code_w), .cnt_o(bit_cnt));

   assign load = (ev == EV_END) && (bit_cnt == CNT_W'(WORD_W));

   dl_bank #(.CODE_W(CODE_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(load), .sel(sel_w), .code(code_w),
      .codes(codes));

   assign code_ch0 = codes[0 +: CODE_W];
   assign code_ch1 = codes[CODE_W +: CODE_W];
   assign dac_on   = ~en_s;
endmodule

// File: rtl/ctl_dac_loader_chk.sv
module ctl_dac_loader_chk #(
   parameter int CODE_W = 8,
   parameter int WORD_W = 12,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code0,
   input logic [CODE_W-1:0] code1,
   input logic              dac_on,
   input logic [CNT_W-1:0]  bit_cnt
);
   // R1: reset forces codes to zero and converters off
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (code0 == '0 && code1 == '0 && !dac_on));

   // R7: a code moves only right after the enable rise is seen
   a_r7_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((code0 != $past(code0)) || (code1 != $past(code1)))
         |-> (!$past(dac_on) && $past(dac_on, 2)));

   // R8: a code moves only when exactly a full word was counted
   a_r8_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((code0 != $past(code0)) || (code1 != $past(code1)))
         |-> ($past(bit_cnt) == CNT_W'(WORD_W)));

   // R9: never both channels in one cycle
   a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      !((code0 != $past(code0)) && (code1 != $past(code1))));

   // R3: bit counter saturates one above the word length
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(WORD_W + 1));
endmodule

bind ctl_dac_loader ctl_dac_loader_chk #(
   .CODE_W(CODE_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .code0(code_ch0), .code1(code_ch1),
   .dac_on(dac_on), .bit_cnt(bit_cnt));

// File: tb/sim_ctl_dac_loader.sv
`timescale 1ns/1ps
module sim_ctl_dac_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
   logic [7:0] code_ch0, code_ch1;
   logic dac_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctl_dac_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_en_n(ser_en_n), .code_ch0(code_ch0), .code_ch1(code_ch1),
      .dac_on(dac_on));

   // Behavioural pin-level model: pins appear after two sync stages,
   // edges are judged one further cycle later.
   bit h1_en, h2_en, h3_en, h1_ck, h2_ck, h3_ck, h2_dt, h1_dt;
   int m_cnt;
   bit [11:0] m_sr;
   bit [7:0] m0, m1;
   bit m_dac;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1_en = 1; h2_en = 1; h3_en = 1;
         h1_ck = 0; h2_ck = 0; h3_ck = 0; h1_dt = 0; h2_dt = 0;
         m_cnt = 0; m_sr = '0; m0 = '0; m1 = '0; m_dac = 0;
      end else begin
         if (h2_en && !h3_en) begin
            if (m_cnt == 12) begin
               if (m_sr[11]) m1 = m_sr[7:0];
               else          m0 = m_sr[7:0];
            end
         end else if (!h2_en && h3_en) begin
            m_cnt = 0; m_sr = '0;
         end else if (!h2_en && h2_ck && !h3_ck) begin
            m_sr = {m_sr[10:0], h2_dt};
            if (m_cnt < 13) m_cnt++;
         end
         m_dac = !h1_en;
         h3_en = h2_en; h2_en = h1_en; h1_en = ser_en_n;
         h3_ck = h2_ck; h2_ck = h1_ck; h1_ck = ser_clk;
         h2_dt = h1_dt; h1_dt = ser_dat;
      end
   end

   // R7 R2: per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (code_ch0 !== m0 || code_ch1 !== m1 || dac_on !== m_dac) begin
            errors++;
            $display("FAIL R7 model: got %h/%h/%b exp %h/%h/%b",
                     code_ch0, code_ch1, dac_on, m0, m1, m_dac);
         end
      end
   end

   task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
      @(negedge clk);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   logic [7:0] e0 = 8'h00, e1 = 8'h00;

   task automatic send(input int n, input logic [15:0] bits, input bit peek);
      ser_en_n = 1'b0;
      hold(4);
      for (int i = 0; i < n; i++) begin
         ser_dat = bits[n-1-i];
         hold(4);
         ser_clk = 1'b1;
         hold(4);
         ser_clk = 1'b0;
      end
      hold(6);
      if (peek) begin
         check("R2 enable low", {8'h00, dac_on}, 9'h001);
         check("R7 no change while shifting ch0", {1'b0, code_ch0}, {1'b0, e0});
         check("R7 no change while shifting ch1", {1'b0, code_ch1}, {1'b0, e1});
      end
      ser_en_n = 1'b1;
      hold(8);
      if (n == 12) begin
         if (bits[11]) e1 = bits[7:0];
         else          e0 = bits[7:0];
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      hold(4);
      rst_n = 1'b1;
      hold(2);
      check("R1 reset ch0", {1'b0, code_ch0}, 9'h000);
      check("R1 reset ch1", {1'b0, code_ch1}, 9'h000);
      check("R1 reset dac_on", {8'h00, dac_on}, 9'h000);

      // R4 R6: select 0, code A5
      send(12, {4'h0, 1'b0, 3'b000, 8'hA5}, 1'b1);
      check("R4 R6 ch0 written", {1'b0, code_ch0}, 9'h0A5);
      check("R2 enable high", {8'h00, dac_on}, 9'h000);

      // R5 R9: select 1, pad bits all ones, ch0 keeps its code
      send(12, {4'h0, 1'b1, 3'b111, 8'h3C}, 1'b1);
      check("R5 pad ignored ch1", {1'b0, code_ch1}, 9'h03C);
      check("R9 ch0 untouched", {1'b0, code_ch0}, 9'h0A5);

      // R3: MSB-first ordering with asymmetric codes
      send(12, {4'h0, 1'b0, 3'b010, 8'h01}, 1'b0);
      check("R3 msb first ch0", {1'b0, code_ch0}, 9'h001);
      send(12, {4'h0, 1'b1, 3'b101, 8'h80}, 1'b0);
      check("R3 msb first ch1", {1'b0, code_ch1}, 9'h080);
      check("R9 ch0 untouched again", {1'b0, code_ch0}, 9'h001);

      // R8: short and long words discarded
      send(11, {5'h00, 3'b000, 8'hFF}, 1'b1);
      check("R8 short word ch0", {1'b0, code_ch0}, 9'h001);
      check("R8 short word ch1", {1'b0, code_ch1}, 9'h080);
      send(13, {3'h0, 1'b0, 1'b1, 3'b000, 8'h5A}, 1'b1);
      check("R8 long word ch0", {1'b0, code_ch0}, 9'h001);
      check("R8 long word ch1", {1'b0, code_ch1}, 9'h080);
      send(0, 16'h0000, 1'b0);
      check("R8 empty word ch0", {1'b0, code_ch0}, 9'h001);

      // R6: full-scale code to ch1, then ch0
      send(12, {4'h0, 1'b1, 3'b000, 8'hFF}, 1'b0);
      check("R6 ch1 full", {1'b0, code_ch1}, 9'h0FF);
      send(12, {4'h0, 1'b0, 3'b000, 8'h6E}, 1'b0);
      check("R6 ch0 code", {1'b0, code_ch0}, 9'h06E);
      check("R6 scenario tracker ch0", {1'b0, code_ch0}, {1'b0, e0});
      check("R6 scenario tracker ch1", {1'b0, code_ch1}, {1'b0, e1});

      // R1: reset in the middle of a word
      ser_en_n = 1'b0;
      hold(6);
      rst_n = 1'b0;
      hold(2);
      ser_en_n = 1'b1;
      hold(2);
      rst_n = 1'b1;
      hold(4);
      check("R1 mid-word reset ch0", {1'b0, code_ch0}, 9'h000);
      check("R1 mid-word reset ch1", {1'b0, code_ch1}, 9'h000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule